// File: doc/BRIEF.md
# UART Register File and Interrupt Front End

This block is the register side of a simple serial port. A host reaches it over a word-indexed register bus with separate read and write strobes and 32-bit data. It keeps one received character, passes one transmitted character at a time, and holds the control, status and configuration words a driver expects to find. It raises one level interrupt. Serial bit timing, baud generation, FIFOs and modem lines are handled elsewhere or not at all. The configuration words (baud, FIFO and millisecond settings) are only stored and read back.

Received characters come in on a valid/ready stream. `rx_ready` is high only while the one-character buffer is empty and no break strobe is present. A byte moves only in a cycle where `rx_valid` and `rx_ready` are both high. A sender that sees `rx_ready` low must hold its byte. A break strobe needs no handshake and is always taken. Transmitted characters leave as a one-cycle `tx_valid` pulse with no back-pressure, so the consumer must take every pulse. Register reads are combinational on the address. All state changes happen at the clock edge that ends the access.

Top module: `uart_regfile`

## Requirements
- R1: After reset the registers read as follows:
  - status 1 (index 0x25) reads 0x6040 and status 2 (0x26) reads 0x4028.
  - the test word (0x2D) reads 0x0060.
  - control 1 (0x20) reads 0, control 2 (0x21) reads 0x0001 and control 3 (0x22) reads 0x0700.
  - baud modulator (0x2A) reads 0 and baud count (0x2B) reads 4.
  - receive data (0x00) reads 0x4000, with error flag bit 14 set.
  - `irq` is low and `rx_ready` is high.
- R2: Writes and reads of the configuration and unmapped indices behave as follows:
  - Writes to 0x20, 0x22, 0x24, 0x2A and 0x2C keep only data bits 15:0, and those bits read back at the same index.
  - A write to the baud increment index 0x29 lands in the word read at 0x2B. Index 0x29 itself reads 0.
  - Writes to 0x23, 0x2B and 0x2D, and to any unmapped index, change nothing. Index 0x23 and unmapped indices read 0.
- R3: A 1 written to status 1 clears that bit only for bits 15, 14, 12, 11, 10, 8, 7, 5 and 4. A 1 written to status 2 clears that bit only for bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2 and 1. Every other written bit is ignored.
- R4: A byte is accepted when `rx_valid` and `rx_ready` are both high. Acceptance has these effects:
  - the byte is stored in bits 7:0 of the receive word;
  - status 1 bit 9 and status 2 bit 0 are set;
  - test bit 5 (receive empty) is cleared;
  - `rx_ready` drops.
  A byte offered while the buffer is full is dropped.
- R5: Reading index 0x00 while the buffer is full returns the stored word with bit 15 set. At the closing edge, that read empties the buffer: status 1 bit 9 and status 2 bit 0 clear, and test bit 5 sets. Reading while the buffer is empty returns the word without bit 15 and changes nothing.
- R6: A `brk_strobe` cycle loads the receive word with 0x0800 (break flag bit 11) and has the same side effects as an accepted byte, whether or not the buffer was full. `rx_ready` is low during the strobe, so a byte offered in the same cycle is not taken.
- R7: When a break or an accepted byte arrives in the same cycle as a read of index 0x00, the read returns the old word and its flag. The new word is then left stored and full.
- R8: `irq` is high when either of two terms holds:
  - status 1 bit 9 and control 1 bit 9 are both set;
  - status 1 bit 13 and control 1 bits 13 and 6 are all set.
- R9: A write to control 2 with bit 0 equal to 0 is a soft reset:
  - status 1, status 2, the test word, control 1, control 3, the baud modulator, the baud count and the receive word return to their R1 values;
  - the FIFO word (0x24) and the millisecond word (0x2C) keep their contents.
- R10: A write to index 0x10 while control 2 bit 2 is set makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to data bits 7:0. When control 2 bit 2 is clear, the write produces no pulse. Status 1 bit 13 stays set throughout.
- R11: Control 2 stores data bits 15:0 with bit 0 forced to 1, so it never reads with bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word index of the accessed register |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, qualifies read side effects |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on bus_addr |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive buffer can take a byte |
| rx_data | input | CHAR_W | Received byte |
| brk_strobe | input | 1 | Break condition seen on the line |
| tx_valid | output | 1 | One-cycle pulse for an outgoing byte |
| tx_data | output | CHAR_W | Outgoing byte |
| irq | output | 1 | Level interrupt request |

## Verification
The host can drain the receive buffer in the very cycle in which a break, or a byte, refills it. The bench provokes this by holding the read strobe on index 0x00 and `brk_strobe` high in the same cycle. It checks that the word returned is the old character with its ready flag, and that a second read afterwards returns 0x8800. It also offers a byte during a break, and then again while the buffer is full, and confirms by reading the buffer that neither byte was taken.

// File: rtl/urf_pkg.sv
`timescale 1ns/1ps
package urf_pkg;

  localparam int REG_W = 16;

  // word indices (byte offset >> 2)
  localparam logic [31:0] IDX_RXD  = 32'h00;
  localparam logic [31:0] IDX_TXD  = 32'h10;
  localparam logic [31:0] IDX_CTL1 = 32'h20;
  localparam logic [31:0] IDX_CTL2 = 32'h21;
  localparam logic [31:0] IDX_CTL3 = 32'h22;
  localparam logic [31:0] IDX_FIFO = 32'h24;
  localparam logic [31:0] IDX_ST1  = 32'h25;
  localparam logic [31:0] IDX_ST2  = 32'h26;
  localparam logic [31:0] IDX_BINC = 32'h29;
  localparam logic [31:0] IDX_BMOD = 32'h2A;
  localparam logic [31:0] IDX_BCNT = 32'h2B;
  localparam logic [31:0] IDX_MSEC = 32'h2C;
  localparam logic [31:0] IDX_TEST = 32'h2D;

  // bit positions
  localparam int RXD_VALID_B = 15;
  localparam int S1_TRDY_B   = 13;
  localparam int S1_RRDY_B   = 9;
  localparam int S2_RDR_B    = 0;
  localparam int T_RXE_B     = 5;
  localparam int C1_TRDY_IE  = 13;
  localparam int C1_RRDY_IE  = 9;
  localparam int C1_TXE_IE   = 6;
  localparam int C2_SRST_B   = 0;
  localparam int C2_TXEN_B   = 2;

  // masks and constant parts
  localparam logic [REG_W-1:0] S1_W1C     = 16'hDDB0;
  localparam logic [REG_W-1:0] S2_W1C     = 16'hBDD6;
  localparam logic [REG_W-1:0] S1_STK_RST = 16'h4000; // line-request status
  localparam logic [REG_W-1:0] S2_STK_RST = 16'h0000;
  localparam logic [REG_W-1:0] S1_FIXED   = 16'h2040; // tx ready, rx idle
  localparam logic [REG_W-1:0] S2_FIXED   = 16'h4028; // tx empty, tx done, carrier
  localparam logic [REG_W-1:0] T_FIXED    = 16'h0040; // tx empty
  localparam logic [REG_W-1:0] RXW_RST    = 16'h4000; // error flag
  localparam logic [REG_W-1:0] RXW_BRK    = 16'h0800; // break flag
  localparam logic [REG_W-1:0] CTL2_RST   = 16'h0001;

  // plain stored configuration words
  localparam int NUM_CFG = 5;

  typedef struct packed {
    logic rxd;
    logic txd;
    logic ctl1;
    logic ctl2;
    logic st1;
    logic st2;
    logic test;
  } sel_t;

  function automatic logic [31:0] cfg_wr_idx(input int k);
    case (k)
      0:       return IDX_CTL3;
      1:       return IDX_FIFO;
      2:       return IDX_BINC;
      3:       return IDX_BMOD;
      default: return IDX_MSEC;
    endcase
  endfunction

  function automatic logic [31:0] cfg_rd_idx(input int k);
    case (k)
      0:       return IDX_CTL3;
      1:       return IDX_FIFO;
      2:       return IDX_BCNT;
      3:       return IDX_BMOD;
      default: return IDX_MSEC;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cfg_rst(input int k);
    case (k)
      0:       return 16'h0700;
      2:       return 16'h0004;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit cfg_soft(input int k);
    return (k == 0) || (k == 2) || (k == 3);
  endfunction

endpackage

// File: rtl/urf_decode.sv
`timescale 1ns/1ps
module urf_decode
  import urf_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]  addr,
  output sel_t               sel,
  output logic [NUM_CFG-1:0] cfg_wr_hit,
  output logic [NUM_CFG-1:0] cfg_rd_hit
);
  logic [31:0] idx;
  assign idx = 32'(addr);

  always_comb begin
    sel.rxd  = (idx == IDX_RXD);
    sel.txd  = (idx == IDX_TXD);
    sel.ctl1 = (idx == IDX_CTL1);
    sel.ctl2 = (idx == IDX_CTL2);
    sel.st1  = (idx == IDX_ST1);
    sel.st2  = (idx == IDX_ST2);
    sel.test = (idx == IDX_TEST);
  end

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg_dec
    assign cfg_wr_hit[k] = (idx == cfg_wr_idx(k));
    assign cfg_rd_hit[k] = (idx == cfg_rd_idx(k));
  end
endmodule

// File: rtl/urf_cfgreg.sv
`timescale 1ns/1ps
module urf_cfgreg #(
  parameter int           W    = 16,
  parameter logic [W-1:0] RST  = '0,
  parameter bit           SOFT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= RST;
    else if (SOFT && soft_rst)  q <= RST;
    else if (we)                q <= wd;
  end
endmodule

// File: rtl/urf_rxbuf.sv
`timescale 1ns/1ps
module urf_rxbuf
  import urf_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load_byte,
  input  logic [CHAR_W-1:0] byte_in,
  input  logic              load_brk,
  input  logic              consume,
  output logic [REG_W-1:0]  word_q,
  output logic              full_q
);
  // line events are applied after bus effects of the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RXW_RST;
      full_q <= 1'b0;
    end else if (load_brk) begin
      word_q <= RXW_BRK;
      full_q <= 1'b1;
    end else if (load_byte) begin
      word_q <= REG_W'(byte_in);
      full_q <= 1'b1;
    end else if (soft_rst) begin
      word_q <= RXW_RST;
      full_q <= 1'b0;
    end else if (consume) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/urf_txpath.sv
`timescale 1ns/1ps
module urf_txpath #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CHAR_W-1:0] din,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= fire;
      if (fire) tx_data <= din;
    end
  end
endmodule

// File: rtl/uart_regfile.sv
`timescale 1ns/1ps
module uart_regfile
  import urf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              brk_strobe,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              irq
);
  sel_t               sel;
  logic [NUM_CFG-1:0] cfg_wr_hit, cfg_rd_hit;
  logic [REG_W-1:0]   wd16;
  logic               unused_wdata_hi;
  logic               soft_rst;

  logic [REG_W-1:0]   ctrl1_q, ctrl2_q, st1_stk, st2_stk;
  logic [REG_W-1:0]   st1_val, st2_val, test_val;
  logic [REG_W-1:0]   rx_word;
  logic               rx_full;
  logic [REG_W-1:0]   cfg_q [NUM_CFG];
  logic [REG_W-1:0]   rd_val;

  assign wd16            = bus_wdata[REG_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];

  urf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr       (bus_addr),
    .sel        (sel),
    .cfg_wr_hit (cfg_wr_hit),
    .cfg_rd_hit (cfg_rd_hit)
  );

  assign soft_rst = bus_wr && sel.ctl2 && !wd16[C2_SRST_B];

  // control words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1_q <= '0;
      ctrl2_q <= CTL2_RST;
    end else begin
      if (soft_rst)               ctrl1_q <= '0;
      else if (bus_wr && sel.ctl1) ctrl1_q <= wd16;
      if (bus_wr && sel.ctl2)     ctrl2_q <= wd16 | CTL2_RST;
    end
  end

  // write-one-to-clear status bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_stk <= S1_STK_RST;
      st2_stk <= S2_STK_RST;
    end else if (soft_rst) begin
      st1_stk <= S1_STK_RST;
      st2_stk <= S2_STK_RST;
    end else if (bus_wr) begin
      if (sel.st1) st1_stk <= st1_stk & ~(wd16 & S1_W1C);
      if (sel.st2) st2_stk <= st2_stk & ~(wd16 & S2_W1C);
    end
  end

  // configuration words
  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    urf_cfgreg #(
      .W    (REG_W),
      .RST  (cfg_rst(k)),
      .SOFT (cfg_soft(k))
    ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .we       (bus_wr && cfg_wr_hit[k]),
      .wd       (wd16),
      .q        (cfg_q[k])
    );
  end

  // receive side
  assign rx_ready = !rx_full && !brk_strobe;

  urf_rxbuf #(.CHAR_W(CHAR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .load_byte (rx_valid && rx_ready),
    .byte_in   (rx_data),
    .load_brk  (brk_strobe),
    .consume   (bus_rd && sel.rxd && rx_full),
    .word_q    (rx_word),
    .full_q    (rx_full)
  );

  // transmit side
  urf_txpath #(.CHAR_W(CHAR_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (bus_wr && sel.txd && ctrl2_q[C2_TXEN_B]),
    .din      (bus_wdata[CHAR_W-1:0]),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  // composed status views
  assign st1_val  = st1_stk | S1_FIXED | (REG_W'(rx_full) << S1_RRDY_B);
  assign st2_val  = st2_stk | S2_FIXED | (REG_W'(rx_full) << S2_RDR_B);
  assign test_val = T_FIXED | (REG_W'(!rx_full) << T_RXE_B);

  assign irq = (st1_val[S1_TRDY_B] && ctrl1_q[C1_TRDY_IE] && ctrl1_q[C1_TXE_IE])
            || (st1_val[S1_RRDY_B] && ctrl1_q[C1_RRDY_IE]);

  // read mux
  always_comb begin
    rd_val = '0;
    if (sel.rxd)  rd_val = rx_word | (REG_W'(rx_full) << RXD_VALID_B);
    if (sel.ctl1) rd_val = ctrl1_q;
    if (sel.ctl2) rd_val = ctrl2_q;
    if (sel.st1)  rd_val = st1_val;
    if (sel.st2)  rd_val = st2_val;
    if (sel.test) rd_val = test_val;
    for (int k = 0; k < NUM_CFG; k++)
      if (cfg_rd_hit[k]) rd_val = cfg_q[k];
  end

  assign bus_rdata = DATA_W'(rd_val);
endmodule

// File: rtl/urf_chk.sv
`timescale 1ns/1ps
module urf_chk
  import urf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [CHAR_W-1:0] wd_lo,
  input logic              rd_flag,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              brk_strobe,
  input logic              tx_valid,
  input logic [CHAR_W-1:0] tx_data,
  input logic              irq,
  input logic              rx_full,
  input logic              tx_en
);
  // R10
  tx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && bus_addr == ADDR_W'(IDX_TXD) && tx_en));

  // R10
  tx_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_data == $past(wd_lo));

  // R4
  accept_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (rx_full && !rx_ready));

  // R6
  brk_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_strobe |-> !rx_ready);

  // R6
  brk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_strobe |=> rx_full);

  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(IDX_RXD) && rd_flag && !brk_strobe
     && !(rx_valid && rx_ready)) |=> !rx_full);

  // R9
  soft_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(IDX_CTL2) && !wd_lo[0]) |=> !irq);
endmodule

bind uart_regfile urf_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .wd_lo      (bus_wdata[CHAR_W-1:0]),
  .rd_flag    (bus_rdata[urf_pkg::RXD_VALID_B]),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .brk_strobe (brk_strobe),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .irq        (irq),
  .rx_full    (rx_full),
  .tx_en      (ctrl2_q[urf_pkg::C2_TXEN_B])
);

// File: tb/uart_regfile_test.sv
`timescale 1ns/1ps
module uart_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        brk_strobe = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  uart_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .brk_strobe(brk_strobe), .tx_valid(tx_valid), .tx_data(tx_data),
    .irq(irq)
  );

  typedef struct packed {
    logic        is_rd;
    logic [9:0]  addr;
    logic [31:0] data;   // write data, or expected read value
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  // R2 R3 R11 register table
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 10'h22, 32'h1234ABCD, 4'd2}, '{1'b1, 10'h22, 32'h0000ABCD, 4'd2},
    '{1'b0, 10'h24, 32'hFFFF0081, 4'd2}, '{1'b1, 10'h24, 32'h00000081, 4'd2},
    '{1'b0, 10'h29, 32'hABCD0055, 4'd2}, '{1'b1, 10'h2B, 32'h00000055, 4'd2},
    '{1'b1, 10'h29, 32'h00000000, 4'd2}, '{1'b0, 10'h2A, 32'h00018001, 4'd2},
    '{1'b1, 10'h2A, 32'h00008001, 4'd2}, '{1'b0, 10'h2C, 32'h000003E8, 4'd2},
    '{1'b1, 10'h2C, 32'h000003E8, 4'd2}, '{1'b0, 10'h23, 32'h0000FFFF, 4'd2},
    '{1'b1, 10'h23, 32'h00000000, 4'd2}, '{1'b0, 10'h2D, 32'h00000000, 4'd2},
    '{1'b1, 10'h2D, 32'h00000060, 4'd2}, '{1'b0, 10'h05, 32'h0000FFFF, 4'd2},
    '{1'b1, 10'h05, 32'h00000000, 4'd2}, '{1'b0, 10'h2B, 32'h00007777, 4'd2},
    '{1'b1, 10'h2B, 32'h00000055, 4'd2}, '{1'b0, 10'h25, 32'h0000FFFF, 4'd3},
    '{1'b1, 10'h25, 32'h00002040, 4'd3}, '{1'b0, 10'h26, 32'h0000FFFF, 4'd3},
    '{1'b1, 10'h26, 32'h00004028, 4'd3}, '{1'b0, 10'h20, 32'hFFFF0241, 4'd2},
    '{1'b1, 10'h20, 32'h00000241, 4'd2}, '{1'b0, 10'h21, 32'h00008005, 4'd11},
    '{1'b1, 10'h21, 32'h00008005, 4'd11}, '{1'b1, 10'h00, 32'h00004000, 4'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // offer one byte for one cycle, report ready seen in that cycle
  task automatic offer(input logic [7:0] b, output logic rdy);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 rdy = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic        r;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_chk("R1 status1", 10'h25, 32'h6040);
    rd_chk("R1 status2", 10'h26, 32'h4028);
    rd_chk("R1 test", 10'h2D, 32'h0060);
    rd_chk("R1 ctrl1", 10'h20, 32'h0000);
    rd_chk("R1 ctrl2", 10'h21, 32'h0001);
    rd_chk("R1 ctrl3", 10'h22, 32'h0700);
    rd_chk("R1 bmod", 10'h2A, 32'h0000);
    rd_chk("R1 bcount", 10'h2B, 32'h0004);
    rd_chk("R1 rxdata", 10'h00, 32'h4000);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) begin
        rd(VECS[i].addr, v);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].data);
      end else begin
        wr(VECS[i].addr, VECS[i].data);
      end
    end

    // R10 transmit enabled (ctrl2 = 0x8005)
    wr(10'h10, 32'hFFFFFF5A);
    chk("R10 pulse", {31'b0, tx_valid}, 32'd1);
    chk("R10 byte", {24'b0, tx_data}, 32'h5A);
    @(negedge clk);
    chk("R10 single cycle", {31'b0, tx_valid}, 32'd0);
    rd_chk("R10 tx ready kept", 10'h25, 32'h2040);
    // R10 transmit disabled
    wr(10'h21, 32'h0001);
    wr(10'h10, 32'h33);
    chk("R10 disabled no pulse", {31'b0, tx_valid}, 32'd0);
    wr(10'h21, 32'h8005);

    // R4 receive one byte
    offer(8'hA5, r);
    chk("R4 ready when empty", {31'b0, r}, 32'd1);
    chk("R4 ready drops", {31'b0, rx_ready}, 32'd0);
    rd_chk("R4 status1", 10'h25, 32'h2240);
    rd_chk("R4 status2", 10'h26, 32'h4029);
    rd_chk("R4 test", 10'h2D, 32'h0040);
    chk("R8 irq rx", {31'b0, irq}, 32'd1);
    offer(8'h11, r);
    chk("R4 ready low when full", {31'b0, r}, 32'd0);

    // R5 read drains
    rd_chk("R5 read full", 10'h00, 32'h80A5);
    rd_chk("R5 status1", 10'h25, 32'h2040);
    rd_chk("R5 status2", 10'h26, 32'h4028);
    rd_chk("R5 test", 10'h2D, 32'h0060);
    chk("R5 irq low", {31'b0, irq}, 32'd0);
    rd_chk("R5 read empty", 10'h00, 32'h00A5);
    chk("R5 ready back", {31'b0, rx_ready}, 32'd1);

    // R6 break with a byte offered in the same cycle
    @(negedge clk);
    brk_strobe = 1'b1; rx_valid = 1'b1; rx_data = 8'h22;
    #1 chk("R6 ready low in break", {31'b0, rx_ready}, 32'd0);
    @(negedge clk);
    brk_strobe = 1'b0; rx_valid = 1'b0;
    rd_chk("R6 break word", 10'h00, 32'h8800);

    // R7 read and break in the same cycle
    offer(8'h3C, r);
    @(negedge clk);
    bus_addr = 10'h00; bus_rd = 1'b1; brk_strobe = 1'b1;
    #1 chk("R7 read returns old", bus_rdata, 32'h803C);
    @(negedge clk);
    bus_rd = 1'b0; brk_strobe = 1'b0;
    rd_chk("R7 test still full", 10'h2D, 32'h0040);
    rd_chk("R7 break kept", 10'h00, 32'h8800);

    // R8 interrupt terms, buffer empty
    wr(10'h20, 32'h2000);
    chk("R8 tx term needs enable", {31'b0, irq}, 32'd0);
    wr(10'h20, 32'h2040);
    chk("R8 tx term", {31'b0, irq}, 32'd1);
    wr(10'h20, 32'h0240);
    chk("R8 rx enable empty", {31'b0, irq}, 32'd0);

    // R9 soft reset
    wr(10'h22, 32'h5555);
    wr(10'h2C, 32'h0123);
    wr(10'h20, 32'h2040);
    offer(8'h77, r);
    wr(10'h21, 32'h0004);
    chk("R9 irq cleared", {31'b0, irq}, 32'd0);
    rd_chk("R11 ctrl2 bit0 forced", 10'h21, 32'h0005);
    rd_chk("R9 ctrl1", 10'h20, 32'h0000);
    rd_chk("R9 ctrl3", 10'h22, 32'h0700);
    rd_chk("R9 bcount", 10'h2B, 32'h0004);
    rd_chk("R9 msec kept", 10'h2C, 32'h0123);
    rd_chk("R9 fifo kept", 10'h24, 32'h0081);
    rd_chk("R9 status1", 10'h25, 32'h6040);
    rd_chk("R9 test", 10'h2D, 32'h0060);
    rd_chk("R9 rxdata", 10'h00, 32'h4000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule